// File: doc/BRIEF.md
# Parity-Protected Direct-Mapped Instruction Cache

This block sits between a CPU instruction-fetch port and a flash engine that returns whole 128-bit lines. It keeps 128 lines in a direct-mapped arrangement. Each stored word holds the 128 data bits and one even-parity bit. A request that finds a valid line with a matching tag and good parity is answered on the cycle after it is accepted, and no flash access is made. Any other request sends the line address to the flash side. When the line comes back, it is forwarded to the CPU and written into the cache in the same cycle.

Each read from storage is checked against its parity bit. A line whose tag matches but whose parity fails is treated as a miss. That line is invalidated and fetched again, and a sticky error flag is raised. A one-shot fault-injection arm makes the next fill store an inverted parity bit, so the checker can be exercised in the field. A single-cycle invalidate-all input clears every line. Software does not see the cache otherwise.

Top module: `ic_parity_cache`

## Requirements
- R1: After reset, req_ready_o is 1, and rsp_valid_o, fl_req_valid_o, par_err_o and inj_pending_o are 0. Every line is invalid, so the first fetch to any address is a miss.
- R2: A request is taken when req_valid_i and req_ready_o are both 1. req_ready_o is 1 only while the block is idle, and it is 0 in any cycle in which rsp_valid_o is 1.
- R3: A hit drives rsp_valid_o high in the cycle right after acceptance, with rsp_data_o equal to the stored line, and issues no flash request.
- R4: A miss drives fl_req_valid_o from the second cycle after acceptance. fl_req_addr_o is the request address with bits [3:0] forced to zero. Both stay unchanged until fl_req_ready_i is seen high.
- R5: In the cycle fl_rsp_valid_i is high for the pending fetch, rsp_valid_o is 1 and rsp_data_o equals fl_rsp_data_i. The line is written with its tag, its valid bit and even parity over the 128 data bits.
- R6: The line index is address bits [10:4] and the tag is bits [31:11]. Bits [3:0] do not affect the lookup. A fetch whose tag differs from the stored tag at the same index is a miss and replaces the line.
- R7: When the tag matches but data XOR parity is 1, the lookup is a miss. The line is fetched again from flash, and par_err_o rises on the next cycle.
- R8: par_err_o stays 1 until par_err_clr_i is pulsed. If a new parity error occurs in the same cycle as the clear, the error wins.
- R9: A pulse on inj_arm_i sets inj_pending_o. The next line fill stores the inverted parity bit and clears inj_pending_o, unless inj_arm_i is high again in that same cycle.
- R10: inv_all_i clears every valid bit in one cycle. If it coincides with a line fill, the response is still delivered, but the filled line is left invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU fetch request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_addr_i | input | 32 | CPU fetch byte address |
| rsp_valid_o | output | 1 | Response line valid |
| rsp_data_o | output | 128 | Response line data |
| fl_req_valid_o | output | 1 | Flash line request valid |
| fl_req_ready_i | input | 1 | Flash accepts the request |
| fl_req_addr_o | output | 32 | Line-aligned flash address |
| fl_rsp_valid_i | input | 1 | Flash line data valid |
| fl_rsp_data_i | input | 128 | Flash line data |
| inv_all_i | input | 1 | Invalidate all lines |
| inj_arm_i | input | 1 | Arm parity corruption of the next fill |
| inj_pending_o | output | 1 | Corruption armed and not yet used |
| par_err_o | output | 1 | Sticky parity error flag |
| par_err_clr_i | input | 1 | Clear the parity error flag |

## Verification
A global invalidate can arrive in the same cycle as the line fill it would otherwise leave behind. The bench provokes this by having its flash model raise inv_all_i on the exact cycle it returns data. It then judges two things: the response still carries the flash line, and a repeat fetch of that address goes to flash again instead of hitting. A second overlap, a parity error flagged during lookup followed by refetch and fill, is judged by the response data of the next generation and by the flash request count.

// File: rtl/ic_parity_cache_pkg.sv
package ic_parity_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FETCH,
    ST_WAIT
  } ic_state_e;
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
  parameter int LINES   = 128,
  parameter int TAG_W   = 21,
  parameter int INDEX_W = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic               wr_en_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic               clr_en_i,
  input  logic               inv_all_i,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic               rd_valid_o
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_mem[idx_i] <= wr_tag_i;
  end

  // one flop per line; global invalidate beats a same-cycle fill
  for (genvar g = 0; g < LINES; g++) begin : g_valid
    logic sel;
    assign sel = (idx_i == INDEX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                valid_q[g] <= 1'b0;
      else if (inv_all_i)         valid_q[g] <= 1'b0;
      else if (sel && wr_en_i)    valid_q[g] <= 1'b1;
      else if (sel && clr_en_i)   valid_q[g] <= 1'b0;
    end
  end

  assign rd_tag_o   = tag_mem[idx_i];
  assign rd_valid_o = valid_q[idx_i];
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store #(
  parameter int LINES   = 128,
  parameter int LINE_W  = 128,
  parameter int INDEX_W = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic               wr_en_i,
  input  logic [LINE_W-1:0]  wr_data_i,
  input  logic               wr_flip_i,
  output logic [LINE_W-1:0]  rd_data_o,
  output logic               rd_par_ok_o
);
  localparam int WORD_W = LINE_W + 1;

  logic [WORD_W-1:0] mem [LINES];
  logic [WORD_W-1:0] rd_word;
  logic              wr_par;

  assign wr_par = (^wr_data_i) ^ wr_flip_i;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[idx_i] <= {wr_par, wr_data_i};
  end

  assign rd_word     = mem[idx_i];
  assign rd_data_o   = rd_word[LINE_W-1:0];
  assign rd_par_ok_o = ~(^rd_word);
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_parity_cache_pkg::*;
#(
  parameter int LADDR_W = 28,
  parameter int INDEX_W = 7,
  parameter int TAG_W   = LADDR_W - INDEX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LADDR_W-1:0] req_line_i,
  output logic               req_ready_o,
  input  logic [TAG_W-1:0]   rd_tag_i,
  input  logic               rd_valid_i,
  input  logic               rd_par_ok_i,
  input  logic               fl_req_ready_i,
  input  logic               fl_rsp_valid_i,
  input  logic               inj_arm_i,
  input  logic               par_err_clr_i,
  output logic [LADDR_W-1:0] line_q_o,
  output logic               fl_req_valid_o,
  output logic               hit_o,
  output logic               fill_o,
  output logic               flip_o,
  output logic               clr_line_o,
  output logic               inj_pending_o,
  output logic               par_err_o
);
  ic_state_e          state_q, state_d;
  logic [LADDR_W-1:0] line_q;
  logic               tag_eq, lookup;
  logic               inj_q, perr_q;

  assign lookup     = (state_q == ST_LOOKUP);
  assign tag_eq     = rd_valid_i && (rd_tag_i == line_q[LADDR_W-1:INDEX_W]);
  assign hit_o      = lookup && tag_eq && rd_par_ok_i;
  assign clr_line_o = lookup && tag_eq && !rd_par_ok_i;
  assign fill_o     = (state_q == ST_WAIT) && fl_rsp_valid_i;
  assign flip_o     = fill_o && inj_q;

  assign req_ready_o    = (state_q == ST_IDLE);
  assign fl_req_valid_o = (state_q == ST_FETCH);
  assign line_q_o       = line_q;
  assign inj_pending_o  = inj_q;
  assign par_err_o      = perr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i)    state_d = ST_LOOKUP;
      ST_LOOKUP: state_d = hit_o ? ST_IDLE : ST_FETCH;
      ST_FETCH:  if (fl_req_ready_i) state_d = ST_WAIT;
      ST_WAIT:   if (fl_rsp_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      inj_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_ready_o && req_valid_i) line_q <= req_line_i;
      inj_q <= inj_arm_i || (inj_q && !fill_o);
      if (clr_line_o)         perr_q <= 1'b1;
      else if (par_err_clr_i) perr_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ic_parity_cache.sv
module ic_parity_cache #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 128,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [LINE_W-1:0] rsp_data_o,
  output logic              fl_req_valid_o,
  input  logic              fl_req_ready_i,
  output logic [ADDR_W-1:0] fl_req_addr_o,
  input  logic              fl_rsp_valid_i,
  input  logic [LINE_W-1:0] fl_rsp_data_i,
  input  logic              inv_all_i,
  input  logic              inj_arm_i,
  output logic              inj_pending_o,
  output logic              par_err_o,
  input  logic              par_err_clr_i
);
  localparam int OFFSET_W = $clog2(LINE_W / 8);
  localparam int INDEX_W  = $clog2(LINES);
  localparam int LADDR_W  = ADDR_W - OFFSET_W;
  localparam int TAG_W    = LADDR_W - INDEX_W;

  logic [LADDR_W-1:0] line_q;
  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   rd_tag;
  logic               rd_valid, rd_par_ok;
  logic [LINE_W-1:0]  rd_data;
  logic               hit, fill, flip, clr_line;
  logic               unused_offset;

  assign unused_offset = ^req_addr_i[OFFSET_W-1:0];
  assign idx           = line_q[INDEX_W-1:0];

  ic_ctrl #(
    .LADDR_W(LADDR_W),
    .INDEX_W(INDEX_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_line_i     (req_addr_i[ADDR_W-1:OFFSET_W]),
    .req_ready_o    (req_ready_o),
    .rd_tag_i       (rd_tag),
    .rd_valid_i     (rd_valid),
    .rd_par_ok_i    (rd_par_ok),
    .fl_req_ready_i (fl_req_ready_i),
    .fl_rsp_valid_i (fl_rsp_valid_i),
    .inj_arm_i      (inj_arm_i),
    .par_err_clr_i  (par_err_clr_i),
    .line_q_o       (line_q),
    .fl_req_valid_o (fl_req_valid_o),
    .hit_o          (hit),
    .fill_o         (fill),
    .flip_o         (flip),
    .clr_line_o     (clr_line),
    .inj_pending_o  (inj_pending_o),
    .par_err_o      (par_err_o)
  );

  ic_tag_store #(
    .LINES  (LINES),
    .TAG_W  (TAG_W),
    .INDEX_W(INDEX_W)
  ) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx),
    .wr_en_i   (fill),
    .wr_tag_i  (line_q[LADDR_W-1:INDEX_W]),
    .clr_en_i  (clr_line),
    .inv_all_i (inv_all_i),
    .rd_tag_o  (rd_tag),
    .rd_valid_o(rd_valid)
  );

  ic_data_store #(
    .LINES  (LINES),
    .LINE_W (LINE_W),
    .INDEX_W(INDEX_W)
  ) u_data (
    .clk_i      (clk_i),
    .idx_i      (idx),
    .wr_en_i    (fill),
    .wr_data_i  (fl_rsp_data_i),
    .wr_flip_i  (flip),
    .rd_data_o  (rd_data),
    .rd_par_ok_o(rd_par_ok)
  );

  assign rsp_valid_o   = hit || fill;
  assign rsp_data_o    = hit ? rd_data : fl_rsp_data_i;
  assign fl_req_addr_o = {line_q, {OFFSET_W{1'b0}}};
endmodule

// File: rtl/ic_parity_cache_checker.sv
module ic_parity_cache_checker #(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 128,
  parameter int OFFSET_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [LINE_W-1:0] rsp_data_o,
  input logic              fl_req_valid_o,
  input logic              fl_req_ready_i,
  input logic [ADDR_W-1:0] fl_req_addr_o,
  input logic              fl_rsp_valid_i,
  input logic [LINE_W-1:0] fl_rsp_data_i,
  input logic              inj_arm_i,
  input logic              inj_pending_o,
  input logic              par_err_o,
  input logic              par_err_clr_i
);
  logic pend_q, fill_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               pend_q <= 1'b0;
    else if (fl_req_valid_o && fl_req_ready_i) pend_q <= 1'b1;
    else if (fl_rsp_valid_i)                   pend_q <= 1'b0;
  end
  assign fill_seen = pend_q && fl_rsp_valid_i;

  a_r2_busy_on_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  a_r2_idle_no_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !fl_req_valid_o);
  a_r3_lookup_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !fl_req_valid_o));
  a_r4_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_valid_o && !fl_req_ready_i) |=> (fl_req_valid_o && $stable(fl_req_addr_o)));
  a_r4_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_valid_o |-> (fl_req_addr_o[OFFSET_W-1:0] == '0));
  a_r5_forward_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_seen |-> (rsp_valid_o && rsp_data_o == fl_rsp_data_i));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !par_err_clr_i) |=> par_err_o);
  a_r9_inj_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_pending_o && !fill_seen) |=> inj_pending_o);
  a_r9_inj_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_pending_o && fill_seen && !inj_arm_i) |=> !inj_pending_o);
endmodule

bind ic_parity_cache ic_parity_cache_checker #(
  .ADDR_W  (ADDR_W),
  .LINE_W  (LINE_W),
  .OFFSET_W(OFFSET_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_data_o    (rsp_data_o),
  .fl_req_valid_o(fl_req_valid_o),
  .fl_req_ready_i(fl_req_ready_i),
  .fl_req_addr_o (fl_req_addr_o),
  .fl_rsp_valid_i(fl_rsp_valid_i),
  .fl_rsp_data_i (fl_rsp_data_i),
  .inj_arm_i     (inj_arm_i),
  .inj_pending_o (inj_pending_o),
  .par_err_o     (par_err_o),
  .par_err_clr_i (par_err_clr_i)
);

// File: tb/ic_parity_cache_bench.sv
module ic_parity_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_addr_i = '0;
  logic         rsp_valid_o;
  logic [127:0] rsp_data_o;
  logic         fl_req_valid_o;
  logic         fl_req_ready_i = 1'b0;
  logic [31:0]  fl_req_addr_o;
  logic         fl_rsp_valid_i = 1'b0;
  logic [127:0] fl_rsp_data_i = '0;
  logic         inv_pulse = 1'b0, inv_fill = 1'b0, inv_all_i;
  logic         inj_arm_i = 1'b0;
  logic         inj_pending_o;
  logic         par_err_o;
  logic         par_err_clr_i = 1'b0;

  assign inv_all_i = inv_pulse | inv_fill;

  always #10 clk = ~clk;

  ic_parity_cache u_ic_parity_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .fl_req_valid_o(fl_req_valid_o), .fl_req_ready_i(fl_req_ready_i),
    .fl_req_addr_o(fl_req_addr_o), .fl_rsp_valid_i(fl_rsp_valid_i),
    .fl_rsp_data_i(fl_rsp_data_i), .inv_all_i(inv_all_i),
    .inj_arm_i(inj_arm_i), .inj_pending_o(inj_pending_o),
    .par_err_o(par_err_o), .par_err_clr_i(par_err_clr_i)
  );

  int checks = 0, errors = 0;
  int cyc = 0, fl_cnt = 0, last_acc = 0, gen = 1;
  bit inv_on_fill = 1'b0;
  bit done = 1'b0;
  logic [31:0]  exp_line = '0;
  logic [127:0] exp_q[$];
  bit           hit_q[$];
  int           acc_q[$];
  int           flc_q[$];
  logic [127:0] mdl [128];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] fdata(input logic [31:0] la, input int g);
    return {la ^ 32'h1357_9BDF, ~la, la + 32'(g), 32'(g) ^ 32'h5A00_0000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issues one fetch and queues the expected response
  task automatic fetch(input logic [31:0] a, input bit exp_hit, input string req);
    logic [127:0] e;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R2 ready when idle", 128'(req_ready_o), 128'd1);
    exp_line = {a[31:4], 4'h0};
    if (exp_hit) e = mdl[a[10:4]];
    else begin
      e = fdata(exp_line, gen);
      mdl[a[10:4]] = e;
    end
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(posedge clk);
    #1;
    last_acc = cyc;
    req_valid_i = 1'b0;
    exp_q.push_back(e);
    hit_q.push_back(exp_hit);
    acc_q.push_back(cyc);
    flc_q.push_back(fl_cnt);
    if (req.len() > 0) ;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  // monitor: pops and compares responses
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected response", rsp_data_o, '0);
        end else begin
          logic [127:0] e;
          bit h;
          int a, f;
          e = exp_q.pop_front();
          h = hit_q.pop_front();
          a = acc_q.pop_front();
          f = flc_q.pop_front();
          chk(rsp_data_o == e, h ? "R3 hit data" : "R5 fill data", rsp_data_o, e);
          if (h) begin
            chk(cyc == a, "R3 hit latency one cycle", 128'(cyc - a), 128'd0);
            chk(fl_cnt == f, "R3 hit makes no flash request", 128'(fl_cnt), 128'(f));
          end else begin
            chk(fl_cnt == f + 1, "R5 miss makes one flash request", 128'(fl_cnt), 128'(f + 1));
          end
        end
      end
    end
  end

  // flash model
  initial begin
    forever begin
      @(negedge clk);
      if (fl_req_valid_o) begin
        logic [31:0] la;
        la = fl_req_addr_o;
        chk(cyc == last_acc + 1, "R4 request timing", 128'(cyc - last_acc), 128'd1);
        chk(la == exp_line, "R4 line address", 128'(la), 128'(exp_line));
        @(negedge clk);
        chk(fl_req_valid_o && fl_req_addr_o == la, "R4 request held",
            128'(fl_req_addr_o), 128'(la));
        fl_req_ready_i = 1'b1;
        @(negedge clk);
        fl_req_ready_i = 1'b0;
        fl_cnt++;
        @(negedge clk);
        @(negedge clk);
        fl_rsp_valid_i = 1'b1;
        fl_rsp_data_i  = fdata(la, gen);
        inv_fill       = inv_on_fill;
        @(negedge clk);
        fl_rsp_valid_i = 1'b0;
        inv_fill       = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready after reset", 128'(req_ready_o), 128'd1);
    chk(!rsp_valid_o && !fl_req_valid_o, "R1 outputs idle",
        128'({rsp_valid_o, fl_req_valid_o}), 128'd0);
    chk(!par_err_o && !inj_pending_o, "R1 flags clear",
        128'({par_err_o, inj_pending_o}), 128'd0);

    // R1 first fetch misses, then R3 hit, R6 offset ignored
    fetch(32'h0000_1230, 1'b0, "R1");
    fetch(32'h0000_1230, 1'b1, "R3");
    fetch(32'h0000_123C, 1'b1, "R6");

    // several indices
    for (int i = 0; i < 4; i++) fetch(32'h0004_0000 + 32'(i * 16), 1'b0, "R5");
    for (int i = 3; i >= 0; i--) fetch(32'h0004_0004 + 32'(i * 16), 1'b1, "R3");

    // R6 same index, other tag: replace
    fetch(32'h0000_1A30, 1'b0, "R6");
    fetch(32'h0000_1A30, 1'b1, "R6");
    fetch(32'h0000_1230, 1'b0, "R6");

    // R10 global invalidate
    pulse(inv_pulse);
    fetch(32'h0000_1230, 1'b0, "R10");
    fetch(32'h0004_0010, 1'b0, "R10");
    fetch(32'h0000_1230, 1'b1, "R10");

    // R9 injection, R7 detection, R8 sticky
    pulse(inj_arm_i);
    chk(inj_pending_o == 1'b1, "R9 arm sets pending", 128'(inj_pending_o), 128'd1);
    gen = 5;
    fetch(32'h0010_0040, 1'b0, "R9");
    chk(inj_pending_o == 1'b0, "R9 pending cleared by fill", 128'(inj_pending_o), 128'd0);
    chk(par_err_o == 1'b0, "R7 no error before read", 128'(par_err_o), 128'd0);
    fetch(32'h0000_1230, 1'b1, "R9 other line unaffected");
    gen = 6;
    fetch(32'h0010_0048, 1'b0, "R7");
    chk(par_err_o == 1'b1, "R7 error flagged", 128'(par_err_o), 128'd1);
    fetch(32'h0010_0040, 1'b1, "R7");
    chk(par_err_o == 1'b1, "R8 error sticky", 128'(par_err_o), 128'd1);
    pulse(par_err_clr_i);
    chk(par_err_o == 1'b0, "R8 error cleared", 128'(par_err_o), 128'd0);

    // R10 invalidate colliding with a fill
    gen = 7;
    inv_on_fill = 1'b1;
    fetch(32'h0020_0070, 1'b0, "R10");
    inv_on_fill = 1'b0;
    fetch(32'h0020_0070, 1'b0, "R10 filled line left invalid");
    fetch(32'h0000_1230, 1'b0, "R10 other line invalid");
    fetch(32'h0020_0070, 1'b1, "R10");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 no pending response", 128'(exp_q.size()), 128'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule